// File: doc/BRIEF.md
# Four-Queue Routed FIFO Controller

This block holds four independent FIFO queues behind one routing layer. The routing topology is chosen once, while master reset is held, from a two-bit configuration input. In demux topology, one write strobe steers a word into the queue named by a write-select input, and each queue is drained through its own read strobe and output slice. In broadcast topology, a single write lands in all four queues on the same edge. In mux topology, each queue has its own write strobe and data slice, and one shared read strobe drains whichever queue the output-select input names.

Each queue can be cleared on its own by a partial reset. This empties it and zeroes its output register, while the other queues and the latched topology are left alone. Every queue reports empty and full, and every output slice has an active-high disable that forces it to zero. Everything runs on one clock, and the reset is synchronous and active low.

Top module: `quad_route_fifo`

## Requirements
- R1: The topology is loaded from `cfg_mode` only on edges where `rst_n` is low. Code 00 gives demux, 01 gives broadcast and 10 gives mux. Changing `cfg_mode` after reset has no effect.
- R2: Code 11 behaves as demux and sets `mode_err_o` to 1. The other three codes leave it at 0. The flag holds its value until the next master reset.
- R3: Each queue returns words in the order they were written. An accepted read loads the queue's output register at the clock edge, so the word appears on the output after that edge.
- R4: In demux, a `wr_en_i[0]` pulse writes slice 0 of `wr_data_i` into the queue numbered `wr_sel_i`. Only that queue changes.
- R5: In broadcast, a `wr_en_i[0]` pulse writes slice 0 into all four queues. The write is dropped entirely when any queue is full.
- R6: In mux, `wr_en_i[k]` writes slice k into queue k. `rd_en_i[0]` pops the queue numbered `out_sel_i`, sampled at that same edge, and that queue's word is shown on slice 0. `rd_en_i[3:1]` are ignored, and slices 1 to 3 read zero.
- R7: In demux and broadcast, `rd_en_i[k]` pops queue k onto slice k, and `out_sel_i` has no effect.
- R8: A write to a full queue is ignored. A read of an empty queue is ignored, and the output register keeps its last word.
- R9: `empty_o[k]` is 1 when queue k holds no words. `full_o[k]` is 1 when it holds DEPTH words.
- R10: A low `qrst_n[k]` at an edge empties queue k and zeroes its output register. The other queues and the topology are kept.
- R11: A high `oe_n_i[k]` forces output slice k to zero. In mux, only `oe_n_i[0]` acts, and it acts on slice 0.
- R12: After master reset, all queues are empty, none is full, and every output slice is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_mode | input | 2 | Topology code, sampled during master reset |
| qrst_n | input | 4 | Per-queue active-low partial reset |
| wr_en_i | input | 4 | Write strobes (bit 0 only, in demux and broadcast) |
| wr_sel_i | input | 2 | Target queue for demux writes |
| wr_data_i | input | 4*W | Write data, one W-bit slice per queue (slice 0 only, in demux and broadcast) |
| rd_en_i | input | 4 | Read strobes (bit 0 is the shared read in mux) |
| out_sel_i | input | 2 | Queue drained by the shared read in mux |
| oe_n_i | input | 4 | Active-high per-slice output disable |
| rd_data_o | output | 4*W | Read data, one W-bit slice per queue |
| empty_o | output | 4 | Per-queue empty flag |
| full_o | output | 4 | Per-queue full flag |
| mode_err_o | output | 1 | Reserved topology code was latched |

## Verification
Demux writes are aimed at one queue at a time. This shows whether the write select reaches only the named queue, and whether a moving output select leaves the per-queue reads alone.

In broadcast, one word written to an empty block must come out of all four queues. The block is then filled, one queue is partly drained, and another write is tried; this separates an "any queue full" gate from a per-queue gate.

In mux, four distinct words go into four queues, then are read back under different output selects, with the unused read strobes toggled. This shows whether the select, and not the strobes, decides the source.

Partial reset, output disables, the reserved code and a change of the configuration code after reset each get a pattern of their own.

// File: rtl/qrf_pkg.sv
// Shared types for the four-queue routed FIFO.
// Assumes the queue count is fixed at four, because the selects are two bits wide.
package qrf_pkg;

    localparam int NQ = 4;

    typedef enum logic [1:0] {
        ROUTE_DEMUX = 2'd0,
        ROUTE_BCAST = 2'd1,
        ROUTE_MUX   = 2'd2
    } route_e;

    // Map a configuration code to a topology; the reserved code falls back to demux.
    function automatic route_e decode_route(input logic [1:0] code);
        case (code)
            2'b01:   return ROUTE_BCAST;
            2'b10:   return ROUTE_MUX;
            default: return ROUTE_DEMUX;
        endcase
    endfunction

endpackage

// File: rtl/qrf_mode_latch.sv
// Holds the routing topology and the reserved-code flag.
// Both are loaded on every edge while master reset is low and hold afterwards.
// Assumes rst_n is synchronous and active low.
module qrf_mode_latch
    import qrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_code,
    output route_e     route_o,
    output logic       err_o
);

    route_e route_q;
    logic   err_q;

    // Load the topology while reset is held; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= decode_route(cfg_code);
            err_q   <= &cfg_code;
        end
    end

    assign route_o = route_q;
    assign err_o   = err_q;

endmodule

// File: rtl/qrf_queue.sv
// One circular FIFO queue with a registered output word.
// A push to a full queue and a pop from an empty queue are both dropped.
// clr_n is a local synchronous clear that acts like rst_n but only on this queue.
module qrf_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    // Advance a pointer, wrapping at the last slot.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= din;
        end
    end

    // Pointer, occupancy and output register update, with master and local clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            dout <= '0;
        end else begin
            if (push_ok) begin
                wp <= step(wp);
            end
            if (pop_ok) begin
                rp   <= step(rp);
                dout <= mem[rp];
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/qrf_router.sv
// Combinational steering of write and read requests for the latched topology.
// Each queue gates its own full and empty cases. This block adds only the
// all-queues gate for broadcast and reports when the shared mux read is taken.
module qrf_router
    import qrf_pkg::*;
#(
    parameter int W = 8
) (
    input  route_e          route,
    input  logic [NQ-1:0]   wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [NQ*W-1:0] wr_data,
    input  logic [NQ-1:0]   rd_en,
    input  logic [1:0]      out_sel,
    input  logic [NQ-1:0]   full,
    input  logic [NQ-1:0]   empty,
    output logic [NQ-1:0]   push,
    output logic [NQ-1:0]   pop,
    output logic [NQ*W-1:0] din,
    output logic            mux_take
);

    // Pick strobes and data paths according to the topology.
    always_comb begin
        push     = '0;
        pop      = '0;
        din      = {NQ{wr_data[W-1:0]}};
        mux_take = 1'b0;
        case (route)
            ROUTE_MUX: begin
                push         = wr_en;
                din          = wr_data;
                pop[out_sel] = rd_en[0];
                mux_take     = rd_en[0] && !empty[out_sel];
            end
            ROUTE_BCAST: begin
                push = {NQ{wr_en[0] && !(|full)}};
                pop  = rd_en;
            end
            default: begin
                push[wr_sel] = wr_en[0];
                pop          = rd_en;
            end
        endcase
    end

endmodule

// File: rtl/qrf_out_stage.sv
// Builds the output slices from the four queue output registers.
// In mux, it remembers which queue the last shared read drained and shows
// that queue's register on slice 0. Every slice can be forced to zero by its disable.
module qrf_out_stage
    import qrf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  route_e          route,
    input  logic            mux_take,
    input  logic [1:0]      out_sel,
    input  logic [NQ-1:0]   oe_n,
    input  logic [NQ*W-1:0] oreg,
    output logic [NQ*W-1:0] rd_data
);

    logic [1:0] src_q;

    // Capture the source of the shared read at the edge the read is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (mux_take) begin
            src_q <= out_sel;
        end
    end

    // Drive each slice, honouring the topology and the disables.
    always_comb begin
        rd_data = '0;
        if (route == ROUTE_MUX) begin
            if (!oe_n[0]) begin
                rd_data[W-1:0] = oreg[src_q*W +: W];
            end
        end else begin
            for (int k = 0; k < NQ; k++) begin
                if (!oe_n[k]) begin
                    rd_data[k*W +: W] = oreg[k*W +: W];
                end
            end
        end
    end

endmodule

// File: rtl/quad_route_fifo.sv
// Top of the four-queue routed FIFO.
// It latches the topology during master reset, steers requests through the router,
// holds four queues that each have a local clear, and forms the output slices.
// Single clock; synchronous active-low reset.
module quad_route_fifo
    import qrf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_mode,
    input  logic [3:0]      qrst_n,
    input  logic [3:0]      wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [4*W-1:0]  wr_data_i,
    input  logic [3:0]      rd_en_i,
    input  logic [1:0]      out_sel_i,
    input  logic [3:0]      oe_n_i,
    output logic [4*W-1:0]  rd_data_o,
    output logic [3:0]      empty_o,
    output logic [3:0]      full_o,
    output logic            mode_err_o
);

    route_e          mode_q;
    logic            mux_active;
    logic [NQ-1:0]   push, pop;
    logic [NQ*W-1:0] din, oreg;
    logic            mux_take;

    qrf_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_code (cfg_mode),
        .route_o  (mode_q),
        .err_o    (mode_err_o)
    );

    assign mux_active = (mode_q == ROUTE_MUX);

    qrf_router #(.W(W)) u_route (
        .route    (mode_q),
        .wr_en    (wr_en_i),
        .wr_sel   (wr_sel_i),
        .wr_data  (wr_data_i),
        .rd_en    (rd_en_i),
        .out_sel  (out_sel_i),
        .full     (full_o),
        .empty    (empty_o),
        .push     (push),
        .pop      (pop),
        .din      (din),
        .mux_take (mux_take)
    );

    for (genvar k = 0; k < NQ; k++) begin : g_q
        qrf_queue #(.W(W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (qrst_n[k]),
            .push  (push[k]),
            .pop   (pop[k]),
            .din   (din[k*W +: W]),
            .dout  (oreg[k*W +: W]),
            .empty (empty_o[k]),
            .full  (full_o[k])
        );
    end

    qrf_out_stage #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .route    (mode_q),
        .mux_take (mux_take),
        .out_sel  (out_sel_i),
        .oe_n     (oe_n_i),
        .oreg     (oreg),
        .rd_data  (rd_data_o)
    );

endmodule

// File: rtl/qrf_checker.sv
// Temporal checks on the routed FIFO ports, attached to the top by bind.
module qrf_checker #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     qrst_n,
    input logic [3:0]     wr_en_i,
    input logic [3:0]     rd_en_i,
    input logic [3:0]     oe_n_i,
    input logic [4*W-1:0] rd_data_o,
    input logic [3:0]     empty_o,
    input logic [3:0]     full_o,
    input logic           mode_err_o,
    input logic           is_mux
);

    // R12: the first cycle after reset shows a cleared block.
    p_reset_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty_o == 4'hF && full_o == 4'h0 && rd_data_o == '0));

    // R2: the reserved-code flag only changes under master reset.
    p_err_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_err_o));

    // R8: with no write strobes, an empty queue stays empty.
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o[0] && wr_en_i == 4'h0) |=> empty_o[0]);

    // R9: a full queue stays full without reads or a partial reset.
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o[1] && rd_en_i == 4'h0 && qrst_n[1]) |=> full_o[1]);

    // R10: a partial reset leaves its queue empty.
    p_qrst_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !qrst_n[2] |=> empty_o[2]);

    // R6: in mux the upper slices stay at zero.
    p_mux_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_mux |-> rd_data_o[4*W-1:W] == '0);

    // R11: with every slice disabled the output is zero.
    p_all_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n_i == 4'hF) |-> rd_data_o == '0);

endmodule

bind quad_route_fifo qrf_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .qrst_n     (qrst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .oe_n_i     (oe_n_i),
    .rd_data_o  (rd_data_o),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .mode_err_o (mode_err_o),
    .is_mux     (mux_active)
);

// File: tb/quad_route_fifo_test.sv
// Directed bench for the routed FIFO: one task per scenario, each checking itself.
module quad_route_fifo_test;

    localparam int W     = 8;
    localparam int DEPTH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     cfg_mode = 2'b00;
    logic [3:0]     qrst_n = 4'hF;
    logic [3:0]     wr_en_i = 4'h0;
    logic [1:0]     wr_sel_i = 2'b00;
    logic [4*W-1:0] wr_data_i = '0;
    logic [3:0]     rd_en_i = 4'h0;
    logic [1:0]     out_sel_i = 2'b00;
    logic [3:0]     oe_n_i = 4'h0;
    logic [4*W-1:0] rd_data_o;
    logic [3:0]     empty_o, full_o;
    logic           mode_err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    quad_route_fifo #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .qrst_n(qrst_n),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .out_sel_i(out_sel_i), .oe_n_i(oe_n_i),
        .rd_data_o(rd_data_o), .empty_o(empty_o), .full_o(full_o),
        .mode_err_o(mode_err_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply_reset(input logic [1:0] code);
        rst_n = 1'b0;
        cfg_mode = code;
        repeat (2) tick();
        rst_n = 1'b1;
    endtask

    task automatic push_one(input logic [1:0] q, input logic [W-1:0] d);
        wr_sel_i = q;
        wr_data_i[W-1:0] = d;
        wr_en_i = 4'h1;
        tick();
        wr_en_i = 4'h0;
    endtask

    task automatic pop_one(input int q, output logic [W-1:0] d);
        rd_en_i[q] = 1'b1;
        tick();
        rd_en_i = 4'h0;
        d = rd_data_o[q*W +: W];
    endtask

    task automatic t_reset();
        apply_reset(2'b00);
        check("R12 empty after reset", empty_o, 4'hF);
        check("R12 full after reset", full_o, 4'h0);
        check("R12 data after reset", rd_data_o, 0);
        check("R2 no error for code 00", mode_err_o, 0);
    endtask

    task automatic t_demux();
        logic [W-1:0] d;
        push_one(2, 8'hA1);
        push_one(2, 8'hA2);
        check("R4 only queue 2 filled", empty_o, 4'b1011);
        push_one(0, 8'hC3);
        out_sel_i = 2'd3;   // R7: must not matter here
        pop_one(2, d);
        check("R3 first word of queue 2", d, 8'hA1);
        out_sel_i = 2'd1;
        pop_one(2, d);
        check("R3 second word of queue 2", d, 8'hA2);
        pop_one(0, d);
        check("R7 queue 0 on own read strobe", d, 8'hC3);
        check("R9 all drained", empty_o, 4'hF);
    endtask

    task automatic t_full();
        logic [W-1:0] d;
        for (int i = 0; i < DEPTH; i++) push_one(1, W'(8'h40 + i));
        check("R9 queue 1 full", full_o, 4'b0010);
        check("R9 queue 1 not empty", empty_o, 4'b1101);
        push_one(1, 8'hEE);
        check("R8 still full after extra write", full_o, 4'b0010);
        for (int i = 0; i < DEPTH; i++) begin
            pop_one(1, d);
            check("R8 contents unchanged by write to full", d, 8'h40 + i);
        end
        check("R9 queue 1 empty again", empty_o[1], 1);
        pop_one(1, d);
        check("R8 empty read keeps last word", d, 8'h40 + DEPTH - 1);
    endtask

    task automatic t_bcast();
        logic [W-1:0] d;
        apply_reset(2'b01);
        push_one(2, 8'h5A);
        check("R5 one write fills all queues", empty_o, 4'h0);
        for (int q = 0; q < 4; q++) begin
            pop_one(q, d);
            check("R5 each queue got the word", d, 8'h5A);
        end
        for (int i = 0; i < DEPTH; i++) push_one(0, W'(8'h60 + i));
        check("R5 all queues full", full_o, 4'hF);
        pop_one(0, d);
        check("R5 queue 0 first", d, 8'h60);
        check("R5 queue 0 no longer full", full_o, 4'b1110);
        push_one(0, 8'h77);
        check("R5 blocked write leaves flags", full_o, 4'b1110);
        for (int i = 1; i < DEPTH; i++) pop_one(0, d);
        check("R5 last word is old data", d, 8'h60 + DEPTH - 1);
        check("R5 blocked word not stored", empty_o[0], 1);
    endtask

    task automatic t_mux();
        logic [W-1:0] d;
        apply_reset(2'b10);
        for (int k = 0; k < 4; k++) wr_data_i[k*W +: W] = W'(8'h10 + k);
        wr_en_i = 4'hF;
        tick();
        wr_en_i = 4'h0;
        check("R6 four ports wrote", empty_o, 4'h0);
        out_sel_i = 2'd2;
        rd_en_i = 4'h1;
        tick();
        rd_en_i = 4'h0;
        check("R6 slice 0 shows queue 2", rd_data_o[W-1:0], 8'h12);
        check("R6 upper slices zero", rd_data_o[4*W-1:W], 0);
        out_sel_i = 2'd3;
        rd_en_i = 4'b1000;
        tick();
        rd_en_i = 4'h0;
        check("R6 upper read strobe ignored", empty_o[3], 0);
        check("R6 output unchanged", rd_data_o[W-1:0], 8'h12);
        rd_en_i = 4'h1;
        tick();
        rd_en_i = 4'h0;
        check("R6 slice 0 shows queue 3", rd_data_o[W-1:0], 8'h13);
        check("R6 flags after two reads", empty_o, 4'b1100);
        oe_n_i = 4'b0001;
        #1;
        check("R11 slice 0 disabled", rd_data_o[W-1:0], 0);
        oe_n_i = 4'b1110;
        #1;
        check("R11 upper disables ignored in mux", rd_data_o[W-1:0], 8'h13);
        oe_n_i = 4'h0;
        wr_data_i[3*W +: W] = 8'h33;
        wr_en_i = 4'b1000;
        tick();
        wr_en_i = 4'h0;
        qrst_n = 4'b0111;
        tick();
        qrst_n = 4'hF;
        check("R10 cleared queue output zero", rd_data_o[W-1:0], 0);
        check("R10 only queue 3 emptied", empty_o, 4'b1100);
        out_sel_i = 2'd1;
        rd_en_i = 4'h1;
        tick();
        rd_en_i = 4'h0;
        d = rd_data_o[W-1:0];
        check("R10 mode and queue 1 kept", d, 8'h11);
    endtask

    task automatic t_err();
        logic [W-1:0] d;
        apply_reset(2'b11);
        check("R2 reserved code flagged", mode_err_o, 1);
        push_one(3, 8'h99);
        check("R2 reserved code routes as demux", empty_o, 4'b0111);
        cfg_mode = 2'b10;
        wr_data_i[W +: W] = 8'h55;
        wr_en_i = 4'b0010;
        tick();
        wr_en_i = 4'h0;
        check("R1 late code change has no effect", empty_o, 4'b0111);
        check("R2 flag held", mode_err_o, 1);
        pop_one(3, d);
        check("R2 demux read of queue 3", d, 8'h99);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_demux();
        t_full();
        t_bcast();
        t_mux();
        t_err();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule